// File: doc/BRIEF.md
# Muting Serial Receiver

This block receives asynchronous serial words of 8 or 9 data bits on a single line. It runs from an oversampling strobe (16 strobes per bit by default) that a baud generator outside the block supplies. It hunts for a falling edge. It confirms the start bit at its centre, then takes each data bit, least significant first, by majority vote of three centre samples. Finally it checks the stop bit. A finished word is placed in a data output. In 9-bit mode the ninth bit goes to a separate output.

Software can put the receiver into a muted state. While muted, no word is delivered and no data or idle flag is raised. The receiver leaves this state by itself in one of two ways, chosen by a method select. In address-mark mode, a word whose most significant bit is 1 ends the mute, and that word is delivered. In idle-line mode, a stretch of high line lasting one full frame ends the mute. Status flags report a waiting word, an overrun, an idle line, noise and a framing error. A single interrupt output combines these flags under two enables.

Top module: `sci_rx_mute`

## Requirements
- R1: Once `rx_en` is 1, a frame in 8-bit mode (`nine_bit`=0) is taken least significant bit first. After the stop bit centre, `rx_data` holds the word and `rdrf` is 1. A pulse on `rd_ack` clears `rdrf`.
- R2: In 9-bit mode (`nine_bit`=1), the ninth data bit received is placed on `rx_bit8`, and the first eight bits are placed on `rx_data`.
- R3: While `rx_en` is 0, `rdrf`, `ovr`, `idle`, `noise` and `ferr` read 0 from the next clock on, and frames on the line are ignored.
- R4: A low pulse that is high again at the start bit centre is rejected, and no word is delivered.
- R5: With `mute`=1 and `wake_addr`=1, words whose most significant bit is 0 are dropped without setting a flag. The most significant bit is `rx_data[7]` in 8-bit mode and the ninth bit in 9-bit mode. A word whose most significant bit is 1 clears `mute` and is delivered.
- R6: When the line has been low at least once since the last idle event, the line staying high for a full frame time sets `idle`. A full frame time is (data bits + 2) × OS strobes. `idle` does not set while muted.
- R7: With `mute`=1 and `wake_addr`=0, the idle event described in R6 clears `mute`. No data is delivered while muted. `mute_set` sets `mute` and `mute_clr` clears it.
- R8: If the three centre samples of the start bit, any data bit or the stop bit disagree, `noise` is set along with the word. The word is still delivered using the majority value.
- R9: A stop bit sampled low sets `ferr`, and the word is still delivered.
- R10: A word that finishes while `rdrf` is 1 sets `ovr` and leaves `rx_data` unchanged. `rd_ack` clears `ovr`, `noise`, `ferr` and `idle`.
- R11: `irq` is 1 when `rie` is 1 and `rdrf` or `ovr` is 1, or when `ilie` is 1 and `idle` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling strobe, OS per bit time |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| nine_bit | input | 1 | 1: 9 data bits, 0: 8 data bits |
| wake_addr | input | 1 | Wake method: 0 idle line, 1 address mark |
| mute_set | input | 1 | Pulse: enter muted state |
| mute_clr | input | 1 | Pulse: leave muted state |
| rd_ack | input | 1 | Pulse: word consumed, clears flags |
| rie | input | 1 | Receive interrupt enable |
| ilie | input | 1 | Idle interrupt enable |
| rx_data | output | 8 | Received data |
| rx_bit8 | output | 1 | Ninth received bit |
| rdrf | output | 1 | Word waiting |
| ovr | output | 1 | Overrun |
| idle | output | 1 | Idle line seen |
| noise | output | 1 | Noise seen in last word |
| ferr | output | 1 | Framing error in last word |
| mute | output | 1 | Receiver muted |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check the following:
- Disabling empties every flag.
- A word can never become ready while the receiver is muted.
- The idle flag never rises out of the muted state.
- Overrun only follows a waiting word.
- Mute falls only by software or by an enabled wake event.
- The word-done pulse lasts a single cycle.

Some behaviour depends on the serial patterns themselves, and only the bench scenarios can show it: bit order, the ninth bit, false-start rejection, majority voting under a glitch, framing errors, the choice between dropping and delivering an address word, and the timing of the idle wake.

// File: rtl/sci_rx_pkg.sv
// Package: shared types for the muting serial receiver.
// Assumes: data words are at most 9 bits wide.
package sci_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       bit8;
        logic       noisy;
        logic       frame_err;
    } rx_word_t;

endpackage

// File: rtl/sci_rx_vote.sv
// Module: three-sample majority vote with a disagreement flag.
// Assumes: samples are taken in order around the bit centre.
module sci_rx_vote (
    input  logic [2:0] samp,
    output logic       level,
    output logic       noisy
);
    // majority value and mismatch detection
    always_comb begin
        level = (samp[0] & samp[1]) | (samp[1] & samp[2]) | (samp[0] & samp[2]);
        noisy = !((samp == 3'b000) || (samp == 3'b111));
    end
endmodule

// File: rtl/sci_rx_frame.sv
// Module: frame engine. It hunts for a start bit, votes three centre
// samples per bit, shifts the data in LSB first and checks the stop bit.
// It emits a one-cycle done pulse with the finished word.
// Assumes: rxd_s is already synchronised; tick arrives OS times per bit.
module sci_rx_frame
    import sci_rx_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     tick,
    input  logic     rxd_s,
    input  logic     nine,
    output logic     done,
    output rx_word_t word
);
    localparam int CW  = $clog2(OS);
    localparam int MID = OS / 2;
    localparam logic [CW-1:0] S0   = CW'(MID - 1);
    localparam logic [CW-1:0] S2   = CW'(MID + 1);
    localparam logic [CW-1:0] LAST = CW'(OS - 1);

    rx_state_e     state;
    logic [CW-1:0] os_cnt;
    logic [3:0]    bit_idx;
    logic [1:0]    samp_q;
    logic [8:0]    shreg;
    logic          noisy_q;
    logic          level;
    logic          nz;
    logic [3:0]    last_bit;
    logic          in_window;

    // vote on the two held samples plus the current one
    sci_rx_vote u_vote (
        .samp  ({samp_q, rxd_s}),
        .level (level),
        .noisy (nz)
    );

    // index of the final data bit for the chosen word length
    always_comb begin
        last_bit  = nine ? 4'd8 : 4'd7;
        in_window = (os_cnt >= S0) && (os_cnt <= S2);
    end

    // frame state machine, sample capture and shifting
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state   <= ST_HUNT;
            os_cnt  <= '0;
            bit_idx <= '0;
            samp_q  <= '0;
            shreg   <= '0;
            noisy_q <= 1'b0;
            done    <= 1'b0;
            word    <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (state == ST_HUNT) begin
                    if (!rxd_s) begin
                        state   <= ST_START;
                        os_cnt  <= CW'(1);
                        noisy_q <= 1'b0;
                    end
                end else begin
                    os_cnt <= (os_cnt == LAST) ? '0 : os_cnt + 1'b1;
                    if (in_window)
                        samp_q <= {samp_q[0], rxd_s};
                    if (os_cnt == S2) begin
                        case (state)
                            ST_START: begin
                                if (level) state <= ST_HUNT;
                                else       noisy_q <= noisy_q | nz;
                            end
                            ST_DATA: begin
                                shreg   <= {level, shreg[8:1]};
                                noisy_q <= noisy_q | nz;
                            end
                            ST_STOP: begin
                                done           <= 1'b1;
                                word.data      <= nine ? shreg[7:0] : shreg[8:1];
                                word.bit8      <= nine & shreg[8];
                                word.noisy     <= noisy_q | nz;
                                word.frame_err <= !level;
                                state          <= ST_HUNT;
                            end
                            default: state <= ST_HUNT;
                        endcase
                    end
                    if (os_cnt == LAST) begin
                        if (state == ST_START) begin
                            state   <= ST_DATA;
                            bit_idx <= '0;
                        end else if (state == ST_DATA) begin
                            if (bit_idx == last_bit) state <= ST_STOP;
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1

endmodule

// File: rtl/sci_rx_idle.sv
// Module: idle-line detector. It counts strobes of unbroken high line and
// fires once when a full frame time has elapsed. It re-arms on any low.
// Assumes: frame time is (data bits + 2) * OS strobes.
module sci_rx_idle #(
    parameter int OS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic rxd_s,
    input  logic nine,
    output logic idle_evt
);
    localparam int CW = $clog2(11 * OS + 1);
    localparam logic [CW-1:0] LIM8 = CW'(10 * OS - 1);
    localparam logic [CW-1:0] LIM9 = CW'(11 * OS - 1);

    logic [CW-1:0] cnt;
    logic          armed;
    logic [CW-1:0] limit;

    // terminal count for the current word length
    always_comb limit = nine ? LIM9 : LIM8;

    // high-run counter with one-shot event
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt      <= '0;
            armed    <= 1'b0;
            idle_evt <= 1'b0;
        end else begin
            idle_evt <= 1'b0;
            if (tick) begin
                if (!rxd_s) begin
                    cnt   <= '0;
                    armed <= 1'b1;
                end else if (armed) begin
                    if (cnt >= limit) begin
                        idle_evt <= 1'b1;
                        armed    <= 1'b0;
                        cnt      <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    AST_IDLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        idle_evt |=> !idle_evt); // R6

endmodule

// File: rtl/sci_rx_mute.sv
// Module: top of the muting serial receiver. It synchronises the line,
// runs the frame engine and idle detector, and keeps the flags, the data
// output, the mute state and the interrupt.
// Assumes: os_tick comes from an external baud generator, OS per bit.
module sci_rx_mute
    import sci_rx_pkg::*;
#(
    parameter int OS   = 16,
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic       rx_en,
    input  logic       nine_bit,
    input  logic       wake_addr,
    input  logic       mute_set,
    input  logic       mute_clr,
    input  logic       rd_ack,
    input  logic       rie,
    input  logic       ilie,
    output logic [7:0] rx_data,
    output logic       rx_bit8,
    output logic       rdrf,
    output logic       ovr,
    output logic       idle,
    output logic       noise,
    output logic       ferr,
    output logic       mute,
    output logic       irq
);
    logic [SYNC-1:0] sync_q;
    logic            rxd_s;
    logic            done;
    rx_word_t        word;
    logic            idle_evt;
    logic            msb;
    logic            wake_mark;
    logic            wake_idle;
    logic            accept;
    logic            full;

    // two-or-more flop synchroniser, line idles high
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC-2:0], rxd};
    end
    assign rxd_s = sync_q[SYNC-1];

    sci_rx_frame #(.OS(OS)) u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rx_en),
        .tick  (os_tick),
        .rxd_s (rxd_s),
        .nine  (nine_bit),
        .done  (done),
        .word  (word)
    );

    sci_rx_idle #(.OS(OS)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (rx_en),
        .tick     (os_tick),
        .rxd_s    (rxd_s),
        .nine     (nine_bit),
        .idle_evt (idle_evt)
    );

    // wake decisions and delivery qualification
    always_comb begin
        msb       = nine_bit ? word.bit8 : word.data[7];
        wake_mark = done & mute & wake_addr & msb;
        wake_idle = idle_evt & mute & !wake_addr;
        accept    = done & (!mute | wake_mark);
        full      = rdrf & !rd_ack;
    end

    // status flags and received data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_bit8 <= 1'b0;
            rdrf    <= 1'b0;
            ovr     <= 1'b0;
            idle    <= 1'b0;
            noise   <= 1'b0;
            ferr    <= 1'b0;
        end else if (!rx_en) begin
            rdrf  <= 1'b0;
            ovr   <= 1'b0;
            idle  <= 1'b0;
            noise <= 1'b0;
            ferr  <= 1'b0;
        end else begin
            if (rd_ack) begin
                rdrf  <= 1'b0;
                ovr   <= 1'b0;
                idle  <= 1'b0;
                noise <= 1'b0;
                ferr  <= 1'b0;
            end
            if (accept) begin
                if (full) begin
                    ovr <= 1'b1;
                end else begin
                    rx_data <= word.data;
                    rx_bit8 <= word.bit8;
                    rdrf    <= 1'b1;
                    noise   <= word.noisy;
                    ferr    <= word.frame_err;
                end
            end
            if (idle_evt && !mute)
                idle <= 1'b1;
        end
    end

    // mute state: software set/clear, hardware clear on wake
    always_ff @(posedge clk) begin
        if (!rst_n)                               mute <= 1'b0;
        else if (mute_clr || wake_mark || wake_idle) mute <= 1'b0;
        else if (mute_set)                        mute <= 1'b1;
    end

    // combined interrupt
    assign irq = (rie & (rdrf | ovr)) | (ilie & idle);

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!rdrf && !ovr && !idle && !noise && !ferr)); // R3
    AST_MUTED_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdrf) |-> !mute); // R5
    AST_MUTED_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> !$past(mute)); // R6
    AST_OVR_AFTER_RDRF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(rdrf)); // R10
    AST_WAKE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mute) && !$past(mute_clr)) |-> $past(rx_en)); // R7

endmodule

// File: tb/sci_rx_mute_tb.sv
// Bench: drives serial frames bit by bit and keeps a behavioural queue of
// expected words. Outputs are compared at the end of every frame and after
// every control action.
module sci_rx_mute_tb;
    localparam int OS  = 16;
    localparam int TPS = 4;              // clocks per strobe
    localparam int BIT = OS * TPS;       // clocks per bit

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic       nine_bit = 1'b0;
    logic       wake_addr = 1'b0;
    logic       mute_set = 1'b0;
    logic       mute_clr = 1'b0;
    logic       rd_ack = 1'b0;
    logic       rie = 1'b0;
    logic       ilie = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit8, rdrf, ovr, idle, noise, ferr, mute, irq;

    int n_chk  = 0;
    int n_fail = 0;
    logic [8:0] exp_q[$];                // words the model expects delivered

    always #10 clk = ~clk;               // 50 MHz

    sci_rx_mute #(.OS(OS)) u_dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .rx_en(rx_en), .nine_bit(nine_bit), .wake_addr(wake_addr),
        .mute_set(mute_set), .mute_clr(mute_clr), .rd_ack(rd_ack),
        .rie(rie), .ilie(ilie), .rx_data(rx_data), .rx_bit8(rx_bit8),
        .rdrf(rdrf), .ovr(ovr), .idle(idle), .noise(noise), .ferr(ferr),
        .mute(mute), .irq(irq)
    );

    // strobe generator: one strobe every TPS clocks
    initial begin
        forever begin
            for (int i = 0; i < TPS; i++) begin
                @(negedge clk);
                os_tick = (i == TPS - 1);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one bit held for a full bit time, optionally flipped briefly at its centre
    task automatic drive_bit(input logic v, input bit glitch);
        for (int c = 0; c < BIT; c++) begin
            rxd = (glitch && c >= 32 && c < 36) ? ~v : v;
            @(negedge clk);
        end
    endtask

    task automatic send(input logic [8:0] w, input bit nine, input bit stop_v, input int gbit);
        int nb;
        nb = nine ? 9 : 8;
        drive_bit(1'b0, 1'b0);
        for (int b = 0; b < nb; b++) drive_bit(w[b], b == gbit);
        drive_bit(stop_v, 1'b0);
        rxd = 1'b1;
    endtask

    task automatic ack();
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_mute(input bit set);
        if (set) mute_set = 1'b1; else mute_clr = 1'b1;
        @(negedge clk);
        mute_set = 1'b0;
        mute_clr = 1'b0;
        @(negedge clk);
    endtask

    // compare delivered word against the model queue head
    task automatic expect_word(input string req, input bit nine);
        logic [8:0] e;
        e = exp_q.pop_front();
        check(req, {31'd0, rdrf}, 32'd1);
        check(req, {24'd0, rx_data}, {24'd0, e[7:0]});
        if (nine) check(req, {31'd0, rx_bit8}, {31'd0, e[8]});
    endtask

    initial begin
        wait_clk(5);
        check("R1 reset rdrf", {31'd0, rdrf}, 32'd0);
        check("R10 reset ovr", {31'd0, ovr}, 32'd0);
        check("R7 reset mute", {31'd0, mute}, 32'd0);
        check("R11 reset irq", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        rx_en = 1'b1;
        rie   = 1'b1;
        wait_clk(3 * BIT);

        // R1: plain 8-bit word, LSB first
        exp_q.push_back(9'h0A5);
        send(9'h0A5, 0, 1, -1);
        expect_word("R1 word A5", 0);
        check("R11 irq on rdrf", {31'd0, irq}, 32'd1);
        check("R9 no ferr", {31'd0, ferr}, 32'd0);
        check("R8 no noise", {31'd0, noise}, 32'd0);
        ack();
        check("R1 rd_ack clears rdrf", {31'd0, rdrf}, 32'd0);
        check("R11 irq drops", {31'd0, irq}, 32'd0);

        // R10: overrun keeps first word
        exp_q.push_back(9'h03C);
        send(9'h03C, 0, 1, -1);
        send(9'h011, 0, 1, -1);
        check("R10 ovr set", {31'd0, ovr}, 32'd1);
        expect_word("R10 data kept", 0);
        ack();
        check("R10 ovr cleared", {31'd0, ovr}, 32'd0);

        // R4: short low pulse rejected
        rxd = 1'b0;
        wait_clk(16);
        rxd = 1'b1;
        wait_clk(3 * BIT);
        check("R4 false start", {31'd0, rdrf}, 32'd0);

        // R8: glitch in data bit 2
        exp_q.push_back(9'h05A);
        send(9'h05A, 0, 1, 2);
        expect_word("R8 majority data", 0);
        check("R8 noise set", {31'd0, noise}, 32'd1);
        ack();
        check("R10 ack clears noise", {31'd0, noise}, 32'd0);

        // R9: stop bit low
        exp_q.push_back(9'h066);
        send(9'h066, 0, 0, -1);
        expect_word("R9 data with bad stop", 0);
        check("R9 ferr set", {31'd0, ferr}, 32'd1);
        wait_clk(3 * BIT);
        ack();
        check("R9 ferr cleared", {31'd0, ferr}, 32'd0);

        // R2: 9-bit words
        nine_bit = 1'b1;
        exp_q.push_back(9'h181);
        send(9'h181, 1, 1, -1);
        expect_word("R2 ninth bit one", 1);
        ack();
        exp_q.push_back(9'h055);
        send(9'h055, 1, 1, -1);
        expect_word("R2 ninth bit zero", 1);
        ack();
        nine_bit = 1'b0;

        // R6: idle flag after a frame of high line
        rie  = 1'b0;
        ilie = 1'b1;
        exp_q.push_back(9'h0C3);
        send(9'h0C3, 0, 1, -1);
        expect_word("R6 lead word", 0);
        ack();
        check("R6 idle not yet", {31'd0, idle}, 32'd0);
        wait_clk(12 * BIT);
        check("R6 idle set", {31'd0, idle}, 32'd1);
        check("R11 irq on idle", {31'd0, irq}, 32'd1);
        ack();
        check("R10 ack clears idle", {31'd0, idle}, 32'd0);
        ilie = 1'b0;
        rie  = 1'b1;

        // R5: address-mark wake
        wake_addr = 1'b1;
        pulse_mute(1);
        check("R7 mute_set", {31'd0, mute}, 32'd1);
        send(9'h012, 0, 1, -1);
        check("R5 dropped while muted", {31'd0, rdrf}, 32'd0);
        check("R5 still muted", {31'd0, mute}, 32'd1);
        check("R11 no irq while muted", {31'd0, irq}, 32'd0);
        exp_q.push_back(9'h093);
        send(9'h093, 0, 1, -1);
        check("R5 mark wakes", {31'd0, mute}, 32'd0);
        expect_word("R5 mark delivered", 0);
        ack();

        // R7: idle-line wake
        wake_addr = 1'b0;
        pulse_mute(1);
        send(9'h044, 0, 1, -1);
        check("R7 word dropped", {31'd0, rdrf}, 32'd0);
        check("R7 muted after frame", {31'd0, mute}, 32'd1);
        wait_clk(12 * BIT);
        check("R7 idle wakes", {31'd0, mute}, 32'd0);
        check("R6 no idle flag from mute", {31'd0, idle}, 32'd0);
        pulse_mute(1);
        pulse_mute(0);
        check("R7 mute_clr", {31'd0, mute}, 32'd0);

        // R3: disable clears flags and ignores line
        exp_q.push_back(9'h077);
        send(9'h077, 0, 1, -1);
        expect_word("R3 word before disable", 0);
        rx_en = 1'b0;
        wait_clk(2);
        check("R3 rdrf cleared", {31'd0, rdrf}, 32'd0);
        send(9'h0E1, 0, 1, -1);
        check("R3 ignored while off", {31'd0, rdrf}, 32'd0);
        rx_en = 1'b1;
        wait_clk(2 * BIT);
        exp_q.push_back(9'h00F);
        send(9'h00F, 0, 1, -1);
        expect_word("R1 after re-enable", 0);
        ack();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule